// File: doc/BRIEF.md
# 5B/4B Receive Code-Group Aligner and Decoder

This block sits behind a descrambler in a 100 Mb/s receive path. It watches the serial bit stream, one bit per `bit_stb` pulse, for the start-of-stream delimiter, the code-group pair J followed by K. It then takes the code-group boundary from the place where that pair ended. The boundary is kept for the whole frame. Every later group of five bits is decoded into a 4-bit nibble and driven on an MII-style receive interface.

The J/K pair comes out as two preamble nibbles of `0101`. Data nibbles follow with a lag of one code-group, which lets the block see an end-of-stream pair before any part of it could reach `rxd`. The frame closes on T followed by R, or on two IDLE groups in a row. A code-group that is not valid data raises `sym_err` for one nibble period.

Top module: `rx_code_aligner`

## Requirements
- R1: While no frame is open, a bit strobe that completes the ten-bit pattern `1100010001` opens a frame. This pattern is J (`11000`) followed by K (`10001`), with the first received bit leftmost. On that same strobe, `rx_dv` and `crs` go high and `rxd` becomes `0101`.
- R2: At the first code-group boundary after the K, `rxd` stays `0101` with `rx_dv` high. The two `0101` nibbles together form the first preamble octet.
- R3: Inside a frame a boundary occurs every five strobes, counted from the K. At each boundary the code-group received one period earlier is decoded, first bit leftmost, with this table: 0=`11110`, 1=`01001`, 2=`10100`, 3=`10101`, 4=`01010`, 5=`01011`, 6=`01110`, 7=`01111`, 8=`10010`, 9=`10011`, A=`10110`, B=`10111`, C=`11010`, D=`11011`, E=`11100`, F=`11101`.
- R4: The boundary comes from the J/K position, whatever bit offset the stream has. The search for J/K runs only while no frame is open. A J or K received inside a frame does not realign the boundary; it is treated as an invalid group.
- R5: T (`01101`) followed by R (`00111`) closes the frame at R's boundary. At that boundary `rx_dv` and `crs` go low and `rxd` becomes 0. Neither T nor R is ever output as data.
- R6: Two consecutive IDLE groups (`11111`) close the frame at the second IDLE's boundary, in the same way as R5.
- R7: Inside a frame, a group that is not in the R3 table is reported one boundary later. This covers invalid codes and also J, K, a lone T and a lone IDLE. In that nibble period `sym_err` is 1, `rxd` is 0 and `rx_dv` stays high.
- R8: After reset, and whenever no frame is open, `rxd`, `rx_dv`, `crs` and `sym_err` are all 0.
- R9: In a cycle without `bit_stb`, no output changes, whatever `bit_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle strobe per received bit |
| bit_in | input | 1 | Descrambled serial bit, valid with `bit_stb` |
| rxd | output | 4 | Decoded receive nibble |
| rx_dv | output | 1 | Receive data valid |
| crs | output | 1 | Carrier sense |
| sym_err | output | 1 | Invalid code-group in the current nibble period |

## Verification
Frames are sent behind prefixes of different bit lengths. This shows that alignment follows the J/K position and not a fixed bit count. A frame that carries all sixteen data codes checks the full decode table and the one-group lag. Separate frames end on T/R and on two IDLEs, which tells the two closing rules apart. A frame laced with J, K, an invalid code, a lone IDLE and a lone T checks that errors are flagged without ending the frame or moving the boundary. A stretch of bit toggling without strobes checks that the outputs hold.

// File: rtl/rx_code_aligner.sv
module rx_code_aligner #(
  parameter int unsigned GRP_BITS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       bit_in,
  output logic [3:0] rxd,
  output logic       rx_dv,
  output logic       crs,
  output logic       sym_err
);
  localparam int unsigned WIN  = 2 * GRP_BITS;
  localparam int unsigned CW   = $clog2(GRP_BITS);
  localparam logic [CW-1:0] LAST = CW'(GRP_BITS - 1);
  localparam logic [4:0] C_J = 5'b11000, C_K = 5'b10001, C_T = 5'b01101,
                         C_R = 5'b00111, C_I = 5'b11111;

  logic [WIN-1:0] sh, sh_n;
  logic [CW-1:0]  cnt;
  logic           in_frame, first;
  logic [4:0]     prev;
  logic [4:0]     dec;
  logic [4:0]     cur;
  logic           fin;

  function automatic logic [4:0] decode(input logic [4:0] c);
    case (c)
      5'b11110: decode = 5'h10; 5'b01001: decode = 5'h11;
      5'b10100: decode = 5'h12; 5'b10101: decode = 5'h13;
      5'b01010: decode = 5'h14; 5'b01011: decode = 5'h15;
      5'b01110: decode = 5'h16; 5'b01111: decode = 5'h17;
      5'b10010: decode = 5'h18; 5'b10011: decode = 5'h19;
      5'b10110: decode = 5'h1A; 5'b10111: decode = 5'h1B;
      5'b11010: decode = 5'h1C; 5'b11011: decode = 5'h1D;
      5'b11100: decode = 5'h1E; 5'b11101: decode = 5'h1F;
      default:  decode = 5'h00;
    endcase
  endfunction

  assign sh_n  = {sh[WIN-2:0], bit_in};
  assign cur   = sh_n[4:0];
  assign dec   = decode(prev);
  assign fin   = (prev == C_T && cur == C_R) || (prev == C_I && cur == C_I);
  assign rx_dv = in_frame;
  assign crs   = in_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0; cnt <= '0; in_frame <= 1'b0; first <= 1'b0;
      prev <= '0; rxd <= '0; sym_err <= 1'b0;
    end else if (bit_stb) begin
      sh <= sh_n;
      if (!in_frame) begin
        if (sh_n == {C_J, C_K}) begin
          in_frame <= 1'b1; first <= 1'b1; cnt <= '0;
          rxd <= 4'b0101; sym_err <= 1'b0;
        end
      end else begin
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        if (cnt == LAST) begin
          prev <= cur;
          if (first) begin
            first <= 1'b0; rxd <= 4'b0101; sym_err <= 1'b0;
          end else if (fin) begin
            in_frame <= 1'b0; rxd <= '0; sym_err <= 1'b0;
          end else begin
            rxd <= dec[4] ? dec[3:0] : 4'b0000;
            sym_err <= ~dec[4];
          end
        end
      end
    end
  end

  assert_jk_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !rx_dv && sh_n == {C_J, C_K}) |=> (rx_dv && crs && rxd == 4'b0101));
  assert_grp_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sym_err |-> (rxd == 4'b0000 && rx_dv));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dv |-> (rxd == 4'b0000 && !sym_err && !crs));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> ($stable(rxd) && $stable(rx_dv) && $stable(sym_err)));
endmodule

// File: tb/rx_code_aligner_test.sv
module rx_code_aligner_test;
  logic clk = 1'b0, rst_n = 1'b0, bit_stb = 1'b0, bit_in = 1'b1;
  logic [3:0] rxd;
  logic rx_dv, crs, sym_err;
  int n_chk = 0, n_fail = 0;

  localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101,
                         R = 5'b00111, I = 5'b11111, BAD = 5'b00000;

  logic [6:0] exp_q[$];
  string      tag_q[$];
  event       grp_ev;

  always #2.5 clk = ~clk;

  rx_code_aligner uut (.clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_in(bit_in),
                       .rxd(rxd), .rx_dv(rx_dv), .crs(crs), .sym_err(sym_err));

  function automatic logic [4:0] enc(input logic [3:0] n);
    logic [4:0] t[16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                          5'b01010, 5'b01011, 5'b01110, 5'b01111,
                          5'b10010, 5'b10011, 5'b10110, 5'b10111,
                          5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {dv,crs,err,rxd} got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_in = b; bit_stb = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); bit_stb = 1'b0;
  endtask

  task automatic grp(input logic [4:0] c, input logic dv, input logic err,
                     input logic [3:0] nib, input string tag);
    for (int i = 4; i >= 1; i--) send_bit(c[i]);
    @(negedge clk); bit_in = c[0]; bit_stb = 1'b1;
    @(posedge clk);
    exp_q.push_back({dv, dv, err, nib});
    tag_q.push_back(tag);
    -> grp_ev;
    #1;
    @(negedge clk); bit_stb = 1'b0;
  endtask

  always @(grp_ev) begin
    #1;
    check(tag_q.pop_front(), {rx_dv, crs, sym_err, rxd}, exp_q.pop_front());
  end

  initial begin
    #(5.0 * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [6:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset", {rx_dv, crs, sym_err, rxd}, 7'b0);

    // frame 1: odd offset, T/R end
    send_bit(0); send_bit(1); send_bit(0);
    grp(I, 0, 0, 4'h0, "R8 idle");
    grp(I, 0, 0, 4'h0, "R8 idle");
    grp(J, 0, 0, 4'h0, "R1 J alone");
    grp(K, 1, 0, 4'h5, "R1 JK open");
    grp(enc(4'hA), 1, 0, 4'h5, "R2 second preamble");
    grp(enc(4'h3), 1, 0, 4'hA, "R3 data A");
    grp(enc(4'hF), 1, 0, 4'h3, "R3 data 3");
    grp(T, 1, 0, 4'hF, "R5 T not output");
    grp(R, 0, 0, 4'h0, "R5 TR close");
    grp(I, 0, 0, 4'h0, "R8 after frame");

    // frame 2: different offset, idle end, hold check
    send_bit(1);
    grp(J, 0, 0, 4'h0, "R4 J offset");
    grp(K, 1, 0, 4'h5, "R4 JK offset");
    grp(enc(4'h0), 1, 0, 4'h5, "R2 preamble");
    grp(enc(4'h5), 1, 0, 4'h0, "R4 data 0");
    grp(enc(4'hC), 1, 0, 4'h5, "R4 data 5");
    snap = {rx_dv, crs, sym_err, rxd};
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); bit_in = i[0];
    end
    check("R9 no strobe hold", {rx_dv, crs, sym_err, rxd}, snap);
    grp(I, 1, 0, 4'hC, "R6 first idle");
    grp(I, 0, 0, 4'h0, "R6 idle close");

    // frame 3: errors
    grp(J, 0, 0, 4'h0, "R8 J");
    grp(K, 1, 0, 4'h5, "R1 open");
    grp(enc(4'h1), 1, 0, 4'h5, "R2 preamble");
    grp(BAD, 1, 0, 4'h1, "R3 data 1");
    grp(enc(4'h2), 1, 1, 4'h0, "R7 invalid");
    grp(J, 1, 0, 4'h2, "R3 data 2");
    grp(K, 1, 1, 4'h0, "R4 J in frame");
    grp(enc(4'h4), 1, 1, 4'h0, "R4 K in frame");
    grp(I, 1, 0, 4'h4, "R4 data 4 kept");
    grp(enc(4'h7), 1, 1, 4'h0, "R7 lone idle");
    grp(T, 1, 0, 4'h7, "R3 data 7");
    grp(enc(4'h9), 1, 1, 4'h0, "R7 lone T");
    grp(T, 1, 0, 4'h9, "R3 data 9");
    grp(R, 0, 0, 4'h0, "R5 close");

    // frame 4: full table
    send_bit(1); send_bit(1);
    grp(J, 0, 0, 4'h0, "R8 J");
    grp(K, 1, 0, 4'h5, "R1 open");
    grp(enc(4'h0), 1, 0, 4'h5, "R2 preamble");
    for (int n = 1; n < 16; n++) grp(enc(4'(n)), 1, 0, 4'(n - 1), "R3 table");
    grp(T, 1, 0, 4'hF, "R3 table F");
    grp(R, 0, 0, 4'h0, "R5 close");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule